// File: doc/BRIEF.md
# Framebuffer Compression Tag Controller

This block sits between a tiled renderer and a 256-bit memory port. Every request names one 256-byte tile, which holds 8x8 pixels of 32-bit RGBA. Each tile keeps its whole slot reserved in external memory. A 4-bit tag in on-chip storage records how many 32-byte beats of that slot hold the tile's packed data. The tag can also mark the tile as one of two solid colours, and then no memory is read at all. The controller itself never packs or unpacks pixels. The client supplies the packed beats on writes and receives them on reads.

Compression is switched on per 64 KB page through a small page map. Each enabled page carries a slice index, and that index picks which 256-tag slice of tag storage the page uses. A page that is switched off always moves a full 8-beat burst and never touches tag storage. A clear operation walks a run of tiles and writes a solid code into each tag. It issues no memory traffic.

The tag encoding is as follows:
- Codes 1 to 8 store that many beats, and 8 means the tile is uncompressed.
- Code 14 is transparent black and code 15 is opaque black.
- Codes 0 and 9 to 13 are reserved.

Pixels are packed with red in bits 31:24 and alpha in bits 7:0. Request ops are 0 for read, 1 for write and 2 for clear; op 3 behaves as a read.

Top module: `fbt_tag_ctrl`

## Requirements
- R1: After reset the block is idle with `req_ready` high and no valid output. Every tag reads as code 8, so a read of an enabled page whose tags were never written moves 8 beats.
- R2: A read or write to a page whose map entry is disabled issues one 8-beat burst. It leaves tag storage unchanged.
- R3: On an enabled page, a write with code 1 to 8 moves exactly that many beats and stores the code. A later read of that tile moves the same number of beats. Every burst starts at the tile base address, which is the tile number shifted left by 8.
- R4: A reserved code (0, 9 to 13), whether written by the client or found in storage, behaves as code 8. A write with a reserved code stores 8.
- R5: A write with code 14 or 15 to an enabled page stores the code with no memory command and no data beats. Its response reports 0 beats.
- R6: A read of a tile whose tag is 14 or 15 issues no memory command. It responds with `rsp_solid` high and `rsp_pixel` equal to 32'h00000000 for code 14 or 32'h000000FF for code 15.
- R7: A clear writes the normalised code into `req_len` consecutive tiles starting at `req_tile`, and the run may cross page boundaries. Tiles in disabled pages are skipped. A length of 0 changes nothing, and a clear never issues memory traffic.
- R8: A write burst flags its final beat with `mem_wlast`. The tag of a written tile changes only in the cycle that final beat is accepted by memory.
- R9: Stalls from either handshake lose nothing:
  - `mem_cmd_valid` and its fields hold steady until accepted.
  - Data beats pass through in order and unmodified.
  - `cli_rlast` marks the last read beat.
- R10: The tag address is the page's slice index followed by the tile number within the page. Two pages mapped to the same index therefore share tags. A map write takes effect from the next cycle.
- R11: Every request ends with exactly one response. The response holds until `rsp_ready` and reports the number of memory beats moved. For reads and writes it also reports the solid state of the tile's effective code; for clears it reports the solid state of the written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Page map write strobe |
| cfg_page | input | ADDR_W-16 | Page map entry to write |
| cfg_en | input | 1 | Compression enable for that page |
| cfg_idx | input | IDX_W | Tag slice index for that page |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_op | input | 2 | 0 read, 1 write, 2 clear |
| req_tile | input | ADDR_W-8 | Tile number (byte address divided by 256) |
| req_code | input | 4 | Write beat count or solid code; clear code |
| req_len | input | LEN_W | Number of tiles for a clear |
| rsp_valid | output | 1 | Completion valid |
| rsp_ready | input | 1 | Completion taken |
| rsp_beats | output | 4 | Memory beats moved |
| rsp_solid | output | 1 | Effective code is a solid colour |
| rsp_pixel | output | 32 | Solid pixel value, else zero |
| mem_cmd_valid | output | 1 | Burst command valid |
| mem_cmd_ready | input | 1 | Burst command accepted |
| mem_cmd_write | output | 1 | Burst is a write |
| mem_cmd_addr | output | ADDR_W | Burst byte address (tile base) |
| mem_cmd_beats | output | 4 | Burst length in beats |
| cli_wdata | input | DATA_W | Client write beat |
| cli_wvalid | input | 1 | Client write beat valid |
| cli_wready | output | 1 | Client write beat taken |
| mem_wdata | output | DATA_W | Memory write beat |
| mem_wvalid | output | 1 | Memory write beat valid |
| mem_wready | input | 1 | Memory write beat accepted |
| mem_wlast | output | 1 | Final beat of the write burst |
| mem_rdata | input | DATA_W | Memory read beat |
| mem_rvalid | input | 1 | Memory read beat valid |
| mem_rready | output | 1 | Memory read beat taken |
| cli_rdata | output | DATA_W | Client read beat |
| cli_rvalid | output | 1 | Client read beat valid |
| cli_rready | input | 1 | Client read beat taken |
| cli_rlast | output | 1 | Final beat of the read burst |

## Verification
The assertions watch several rules on every cycle:
- A command's burst length stays within 1 to 8 beats.
- A disabled page never sees a short burst.
- A held command or response does not change while stalled.
- A tag commit lines up with exactly as many accepted write beats as the committed code demands.
- Stored codes are never reserved.
- A solid request completes with no memory phase.
- Page map writes land in the entry they name.

Only the bench scenarios show effects that span requests:
- a tag written earlier changing the burst length of a later read;
- two pages sharing a slice;
- a clear running across a page boundary while skipping disabled pages;
- a disabled-page write leaving stored tags alone.

// File: rtl/fbt_pkg.sv
`timescale 1ns/1ps
package fbt_pkg;

  localparam int TILE_SHIFT = 8;   // 256-byte tiles
  localparam int TILE_IDX_W = 8;   // 256 tiles in a 64 KB page
  localparam int CODE_W     = 4;

  localparam logic [CODE_W-1:0] TAG_RAW       = 4'd8;
  localparam logic [CODE_W-1:0] TAG_SOLID_CLR = 4'd14;
  localparam logic [CODE_W-1:0] TAG_SOLID_BLK = 4'd15;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_CLEAR = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WDATA, S_RDATA, S_CLR, S_RSP
  } fbt_state_e;

  function automatic logic tag_is_solid(input logic [CODE_W-1:0] c);
    return (c == TAG_SOLID_CLR) || (c == TAG_SOLID_BLK);
  endfunction

  // Reserved codes collapse to the uncompressed code.
  function automatic logic [CODE_W-1:0] tag_norm(input logic [CODE_W-1:0] c);
    if (tag_is_solid(c)) return c;
    if (c >= 4'd1 && c <= 4'd8) return c;
    return TAG_RAW;
  endfunction

  // Memory beats needed to move a tile carrying this code.
  function automatic logic [CODE_W-1:0] tag_beats(input logic [CODE_W-1:0] c);
    if (tag_is_solid(c)) return 4'd0;
    return tag_norm(c);
  endfunction

  // RGBA packed R[31:24] G[23:16] B[15:8] A[7:0].
  function automatic logic [31:0] solid_rgba(input logic [CODE_W-1:0] c);
    return (c == TAG_SOLID_BLK) ? 32'h0000_00FF : 32'h0000_0000;
  endfunction

endpackage

// File: rtl/fbt_page_map.sv
`timescale 1ns/1ps
module fbt_page_map #(
  parameter int PG_W  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PG_W-1:0]  cfg_page,
  input  logic             cfg_en,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [PG_W-1:0]  lk_page,
  output logic             lk_en,
  output logic [IDX_W-1:0] lk_idx
);
  localparam int PAGES = 1 << PG_W;

  logic [PAGES-1:0] en_q;
  logic [IDX_W-1:0] idx_q [PAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int p = 0; p < PAGES; p++) idx_q[p] <= '0;
    end else if (cfg_we) begin
      en_q[cfg_page]  <= cfg_en;
      idx_q[cfg_page] <= cfg_idx;
    end
  end

  assign lk_en  = en_q[lk_page];
  assign lk_idx = idx_q[lk_page];

  AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q[$past(cfg_page)] == $past(cfg_en)) &&
               (idx_q[$past(cfg_page)] == $past(cfg_idx))); // R10

endmodule

// File: rtl/fbt_tag_ram.sv
`timescale 1ns/1ps
module fbt_tag_ram
  import fbt_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic [CODE_W-1:0] rd_code,
  input  logic              we,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CODE_W-1:0] wr_code
);
  localparam int DEPTH = 1 << AW;

  logic [CODE_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= TAG_RAW;
    end else if (we) begin
      cell_q[wr_addr] <= wr_code;
    end
  end

  assign rd_code = cell_q[rd_addr];

  AST_STORED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wr_code == tag_norm(wr_code))); // R4

endmodule

// File: rtl/fbt_tag_ctrl.sv
`timescale 1ns/1ps
module fbt_tag_ctrl
  import fbt_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 2,
  parameter int LEN_W  = 9,
  parameter int DATA_W = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-17:0]    cfg_page,
  input  logic                  cfg_en,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [ADDR_W-9:0]     req_tile,
  input  logic [3:0]            req_code,
  input  logic [LEN_W-1:0]      req_len,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [3:0]            rsp_beats,
  output logic                  rsp_solid,
  output logic [31:0]           rsp_pixel,
  output logic                  mem_cmd_valid,
  input  logic                  mem_cmd_ready,
  output logic                  mem_cmd_write,
  output logic [ADDR_W-1:0]     mem_cmd_addr,
  output logic [3:0]            mem_cmd_beats,
  input  logic [DATA_W-1:0]     cli_wdata,
  input  logic                  cli_wvalid,
  output logic                  cli_wready,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  mem_wvalid,
  input  logic                  mem_wready,
  output logic                  mem_wlast,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic                  mem_rvalid,
  output logic                  mem_rready,
  output logic [DATA_W-1:0]     cli_rdata,
  output logic                  cli_rvalid,
  input  logic                  cli_rready,
  output logic                  cli_rlast
);
  localparam int TILE_W = ADDR_W - TILE_SHIFT;
  localparam int PG_W   = TILE_W - TILE_IDX_W;
  localparam int TAG_AW = IDX_W + TILE_IDX_W;

  fbt_state_e          st_q;
  logic                op_wr_q;
  logic                pg_en_q;
  logic [CODE_W-1:0]   beats_q, code_q, cnt_q, wseen_q;
  logic [TAG_AW-1:0]   taddr_q;
  logic [TILE_W-1:0]   cmd_tile_q, cur_tile_q;
  logic [LEN_W-1:0]    left_q;

  // Lookup path: the clear walker owns it while clearing, else the request.
  logic [TILE_W-1:0]   lk_tile;
  logic                pt_en;
  logic [IDX_W-1:0]    pt_idx;
  logic [TAG_AW-1:0]   tag_raddr;
  logic [CODE_W-1:0]   tag_rd_code;

  assign lk_tile   = (st_q == S_CLR) ? cur_tile_q : req_tile;
  assign tag_raddr = {pt_idx, lk_tile[TILE_IDX_W-1:0]};

  fbt_page_map #(.PG_W(PG_W), .IDX_W(IDX_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_page (cfg_page),
    .cfg_en   (cfg_en),
    .cfg_idx  (cfg_idx),
    .lk_page  (lk_tile[TILE_W-1:TILE_IDX_W]),
    .lk_en    (pt_en),
    .lk_idx   (pt_idx)
  );

  // Acceptance decode.
  logic              is_wr, is_clr;
  logic [CODE_W-1:0] wr_code, acc_code, acc_beats;
  logic              acc_solid;

  assign req_ready = (st_q == S_IDLE);
  assign is_wr     = (req_op == OP_WRITE);
  assign is_clr    = (req_op == OP_CLEAR);
  assign wr_code   = tag_norm(req_code);
  assign acc_code  = !pt_en ? TAG_RAW : (is_wr ? wr_code : tag_norm(tag_rd_code));
  assign acc_beats = tag_beats(acc_code);
  assign acc_solid = tag_is_solid(acc_code);

  // Named events.
  logic req_fire, cmd_fire, w_fire, r_fire, beat_last;
  logic solid_wr_ev, commit_ev, clr_step_ev, clr_wr_ev, solid_done_ev;

  assign req_fire      = req_valid & req_ready;
  assign cmd_fire      = mem_cmd_valid & mem_cmd_ready;
  assign w_fire        = (st_q == S_WDATA) & cli_wvalid & mem_wready;
  assign r_fire        = (st_q == S_RDATA) & mem_rvalid & cli_rready;
  assign beat_last     = (cnt_q == beats_q - 4'd1);
  assign solid_wr_ev   = req_fire & is_wr & pt_en & acc_solid;
  assign solid_done_ev = req_fire & !is_clr & acc_solid;
  assign commit_ev     = w_fire & beat_last & pg_en_q;
  assign clr_step_ev   = (st_q == S_CLR) & (left_q != '0);
  assign clr_wr_ev     = clr_step_ev & pt_en;

  logic              tag_we;
  logic [TAG_AW-1:0] tag_waddr;
  logic [CODE_W-1:0] tag_wcode;

  assign tag_we    = solid_wr_ev | commit_ev | clr_wr_ev;
  assign tag_waddr = commit_ev ? taddr_q : tag_raddr;
  assign tag_wcode = (st_q == S_IDLE) ? wr_code : code_q;

  fbt_tag_ram #(.AW(TAG_AW)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (tag_raddr),
    .rd_code (tag_rd_code),
    .we      (tag_we),
    .wr_addr (tag_waddr),
    .wr_code (tag_wcode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      op_wr_q    <= 1'b0;
      pg_en_q    <= 1'b0;
      beats_q    <= '0;
      code_q     <= TAG_RAW;
      cnt_q      <= '0;
      taddr_q    <= '0;
      cmd_tile_q <= '0;
      cur_tile_q <= '0;
      left_q     <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_fire) begin
          op_wr_q    <= is_wr;
          pg_en_q    <= pt_en;
          taddr_q    <= tag_raddr;
          cmd_tile_q <= req_tile;
          cnt_q      <= '0;
          if (is_clr) begin
            cur_tile_q <= req_tile;
            left_q     <= req_len;
            code_q     <= wr_code;
            beats_q    <= '0;
            st_q       <= S_CLR;
          end else begin
            code_q  <= acc_code;
            beats_q <= acc_beats;
            st_q    <= acc_solid ? S_RSP : S_CMD;
          end
        end
        S_CMD: if (cmd_fire) st_q <= op_wr_q ? S_WDATA : S_RDATA;
        S_WDATA, S_RDATA: if (w_fire || r_fire) begin
          if (beat_last) begin
            cnt_q <= '0;
            st_q  <= S_RSP;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        S_CLR: if (clr_step_ev) begin
          cur_tile_q <= cur_tile_q + 1'b1;
          left_q     <= left_q - 1'b1;
        end else begin
          st_q <= S_RSP;
        end
        S_RSP: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // Memory command.
  assign mem_cmd_valid = (st_q == S_CMD);
  assign mem_cmd_write = op_wr_q;
  assign mem_cmd_addr  = {cmd_tile_q, {TILE_SHIFT{1'b0}}};
  assign mem_cmd_beats = beats_q;

  // Write data pass-through.
  assign mem_wdata  = cli_wdata;
  assign mem_wvalid = (st_q == S_WDATA) & cli_wvalid;
  assign cli_wready = (st_q == S_WDATA) & mem_wready;
  assign mem_wlast  = (st_q == S_WDATA) & beat_last;

  // Read data pass-through.
  assign cli_rdata  = mem_rdata;
  assign cli_rvalid = (st_q == S_RDATA) & mem_rvalid;
  assign mem_rready = (st_q == S_RDATA) & cli_rready;
  assign cli_rlast  = (st_q == S_RDATA) & beat_last;

  // Completion.
  assign rsp_valid = (st_q == S_RSP);
  assign rsp_beats = beats_q;
  assign rsp_solid = tag_is_solid(code_q);
  assign rsp_pixel = solid_rgba(code_q);

  // Write beats accepted since the last command, kept for the checks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wseen_q <= '0;
    else if (cmd_fire) wseen_q <= '0;
    else if (w_fire)   wseen_q <= wseen_q + 4'd1;
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_addr) &&
      $stable(mem_cmd_beats) && $stable(mem_cmd_write)); // R9
  AST_CMD_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (mem_cmd_beats >= 4'd1) && (mem_cmd_beats <= 4'd8)); // R3
  AST_RAW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !pg_en_q |-> mem_cmd_beats == TAG_RAW); // R2
  AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> (wseen_q + 4'd1) == tag_beats(tag_wcode)); // R8
  AST_SOLID_SKIPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    solid_done_ev |=> rsp_valid && rsp_beats == 4'd0 && rsp_solid); // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_beats) &&
      $stable(rsp_pixel) && $stable(rsp_solid)); // R11

endmodule

// File: tb/test_fbt_tag_ctrl.sv
`timescale 1ns/1ps
module test_fbt_tag_ctrl;

  localparam int ADDR_W = 20;
  localparam int IDX_W  = 2;
  localparam int LEN_W  = 9;
  localparam int DATA_W = 256;
  localparam int TILE_W = ADDR_W - 8;
  localparam int PG_W   = TILE_W - 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              cfg_we = 0, cfg_en = 0;
  logic [PG_W-1:0]   cfg_page = '0;
  logic [IDX_W-1:0]  cfg_idx = '0;
  logic              req_valid = 0, req_ready;
  logic [1:0]        req_op = '0;
  logic [TILE_W-1:0] req_tile = '0;
  logic [3:0]        req_code = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              rsp_valid, rsp_ready = 0, rsp_solid;
  logic [3:0]        rsp_beats;
  logic [31:0]       rsp_pixel;
  logic              mem_cmd_valid, mem_cmd_ready = 0, mem_cmd_write;
  logic [ADDR_W-1:0] mem_cmd_addr;
  logic [3:0]        mem_cmd_beats;
  logic [DATA_W-1:0] cli_wdata = '0, mem_wdata, mem_rdata = '0, cli_rdata;
  logic              cli_wvalid = 0, cli_wready, mem_wvalid, mem_wready = 0, mem_wlast;
  logic              mem_rvalid = 0, mem_rready, cli_rvalid, cli_rready = 0, cli_rlast;

  fbt_tag_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) i_fbt_tag_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_en(cfg_en), .cfg_idx(cfg_idx),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_tile(req_tile),
    .req_code(req_code), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_beats(rsp_beats),
    .rsp_solid(rsp_solid), .rsp_pixel(rsp_pixel),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_write(mem_cmd_write),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_beats(mem_cmd_beats),
    .cli_wdata(cli_wdata), .cli_wvalid(cli_wvalid), .cli_wready(cli_wready),
    .mem_wdata(mem_wdata), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wlast(mem_wlast),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_rready(mem_rready),
    .cli_rdata(cli_rdata), .cli_rvalid(cli_rvalid), .cli_rready(cli_rready), .cli_rlast(cli_rlast)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Reference state kept by the bench.
  bit         m_en  [16];
  bit [1:0]   m_idx [16];
  bit [3:0]   m_tag [1024];

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Effective code as the requirements define it (R4: reserved -> 8).
  function automatic bit [3:0] ref_norm(input bit [3:0] c);
    case (c)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd14, 4'd15: return c;
      default: return 4'd8;
    endcase
  endfunction

  function automatic bit ref_solid(input bit [3:0] c);
    return c[3] & c[2] & c[1];
  endfunction

  function automatic bit [3:0] ref_beats(input bit [3:0] c);
    return ref_solid(c) ? 4'd0 : ref_norm(c);
  endfunction

  function automatic bit [DATA_W-1:0] pat(input int s, input int i);
    return {8{32'(s * 131 + i * 7 + 1)}};
  endfunction

  function automatic bit rnd(input int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic set_page(input int pg, input bit en, input int idx);
    @(negedge clk);
    cfg_we = 1; cfg_page = PG_W'(pg); cfg_en = en; cfg_idx = IDX_W'(idx);
    @(negedge clk);
    cfg_we = 0;
    m_en[pg] = en; m_idx[pg] = 2'(idx);
  endtask

  // One request with random stalls; checks traffic and completion.
  task automatic run(input string rq, input int op, input int tile, input int code,
                     input int len, input int pct);
    bit [11:0] t12 = 12'(tile);
    int  pg = int'(t12[11:8]);
    bit [9:0] slot = {m_idx[pg], t12[7:0]};
    bit [3:0] c;
    bit [3:0] eb;
    int  seed = $urandom_range(1000);
    int  ncmd = 0, wc = 0, rc = 0, cyc = 0;
    bit  acc = 0, done = 0;
    if (op == 2)      c = ref_norm(4'(code));
    else if (!m_en[pg]) c = 4'd8;
    else if (op == 1) c = ref_norm(4'(code));
    else              c = ref_norm(m_tag[slot]);
    eb = (op == 2) ? 4'd0 : ref_beats(c);
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_tile = t12; req_code = 4'(code); req_len = LEN_W'(len);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (acc) req_valid = 0;
      mem_cmd_ready = rnd(pct); mem_wready = rnd(pct); mem_rvalid = rnd(pct);
      cli_wvalid = rnd(pct); cli_rready = rnd(pct); rsp_ready = rnd(pct);
      cli_wdata = pat(seed, wc); mem_rdata = pat(seed + 77, rc);
      #1;
      if (req_valid && req_ready) acc = 1;
      if (mem_cmd_valid && mem_cmd_ready) begin
        ncmd++;
        chk(rq, "cmd_addr", mem_cmd_addr, {t12, 8'h00});
        chk(rq, "cmd_beats", mem_cmd_beats, eb);
        chk(rq, "cmd_write", mem_cmd_write, op == 1);
      end
      if (mem_wvalid && mem_wready) begin
        chk(rq, "wdata", mem_wdata == pat(seed, wc), 1);
        chk(rq, "wlast", mem_wlast, wc == eb - 1);
        wc++;
      end
      if (cli_rvalid && cli_rready) begin
        chk(rq, "rdata", cli_rdata == pat(seed + 77, rc), 1);
        chk(rq, "rlast", cli_rlast, rc == eb - 1);
        rc++;
      end
      if (rsp_valid && rsp_ready) begin
        chk(rq, "rsp_beats", rsp_beats, eb);
        chk(rq, "rsp_solid", rsp_solid, ref_solid(c));
        chk(rq, "rsp_pixel", rsp_pixel, (c == 4'd15) ? 32'hFF : 32'h0);
        done = 1;
      end
      if (cyc > 3000) begin
        chk(rq, "request timeout", cyc, 0);
        done = 1;
      end
    end
    @(negedge clk);
    req_valid = 0; mem_cmd_ready = 0; mem_wready = 0; mem_rvalid = 0;
    cli_wvalid = 0; cli_rready = 0; rsp_ready = 0;
    chk(rq, "cmd_count", ncmd, eb != 0);
    chk(rq, "wbeats", wc, (op == 1) ? int'(eb) : 0);
    chk(rq, "rbeats", rc, (op == 0 || op == 3) ? int'(eb) : 0);
    if (op == 1 && m_en[pg]) m_tag[slot] = ref_norm(4'(code));
    if (op == 2) begin
      for (int i = 0; i < len; i++) begin
        bit [11:0] tt = 12'(tile + i);
        if (m_en[tt[11:8]]) m_tag[{m_idx[tt[11:8]], tt[7:0]}] = ref_norm(4'(code));
      end
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20170510));
    for (int i = 0; i < 1024; i++) m_tag[i] = 4'd8;
    for (int p = 0; p < 16; p++) begin m_en[p] = 0; m_idx[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "cmd_valid", mem_cmd_valid, 0);

    set_page(0, 1, 0);
    run("R1", 0, 12'h005, 0, 0, 100);           // fresh tag -> 8 beats

    set_page(1, 1, 1);
    run("R3", 1, 12'h110, 3, 0, 100);
    set_page(1, 0, 1);
    run("R2", 1, 12'h110, 5, 0, 80);            // disabled: 8 beats, tag kept
    run("R2", 0, 12'h110, 0, 0, 80);
    set_page(1, 1, 1);
    run("R2", 0, 12'h110, 0, 0, 100);           // still 3

    for (int k = 1; k <= 8; k++) begin
      run("R3", 1, 12'h020 + k, k, 0, 70);
      run("R3", 0, 12'h020 + k, 0, 0, 70);
    end
    run("R4", 1, 12'h031, 0, 0, 100);
    run("R4", 0, 12'h031, 0, 0, 100);
    run("R4", 1, 12'h032, 11, 0, 100);
    run("R4", 0, 12'h032, 0, 0, 100);

    run("R5", 1, 12'h040, 14, 0, 100);
    run("R6", 0, 12'h040, 0, 0, 100);
    run("R5", 1, 12'h041, 15, 0, 60);
    run("R6", 0, 12'h041, 0, 0, 60);

    set_page(2, 1, 1);                          // aliases page 1's slice
    run("R10", 0, 12'h210, 0, 0, 100);          // sees 3 written via page 1

    run("R7", 2, 12'h0FE, 15, 4, 100);          // crosses page 0 -> 1
    run("R7", 0, 12'h0FF, 0, 0, 100);
    run("R7", 0, 12'h101, 0, 0, 100);
    run("R7", 0, 12'h102, 0, 0, 100);           // beyond the run
    run("R7", 2, 12'h022, 14, 0, 100);          // length 0
    run("R7", 0, 12'h022, 0, 0, 100);
    run("R7", 2, 12'h320, 14, 1, 100);          // page 3 disabled
    set_page(3, 1, 2);
    run("R7", 0, 12'h320, 0, 0, 100);

    run("R8", 1, 12'h050, 8, 0, 25);
    run("R8", 0, 12'h050, 0, 0, 25);
    run("R8", 1, 12'h051, 6, 0, 35);
    run("R8", 0, 12'h051, 0, 0, 35);

    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(3);
      int tile = $urandom_range(12'h5FF);
      int code = $urandom_range(15);
      int len = $urandom_range(20);
      int pct = 30 + $urandom_range(70);
      if ($urandom_range(19) == 0)
        set_page($urandom_range(5), $urandom_range(3) != 0, $urandom_range(3));
      run("R9", op, tile, code, len, pct);
    end
    run("R11", 0, 12'h050, 0, 0, 10);

    summary();
    $finish;
  end

endmodule